// File: doc/BRIEF.md
# Digital Pulse-Width Pulse-Position Modulator

This block turns a stream of edge-position word pairs into one pulse per carrier period. A fast clock runs at 2^PHASE_W times the carrier rate. A free-running phase counter splits each carrier period into 2^PHASE_W slots, which is 64 slots at the default width of 6. One word sets the slot where the pulse rises and the other sets the slot where it falls. Because the two edges are placed independently, the block controls both the width and the position of each pulse. All timing comes from the fast clock, so no adjustable delay is involved.

A new word pair is taken only at the boundary between two carrier periods. The output is a registered flop, so each edge lands exactly one fast-clock cycle after the slot it was selected for. If the fall word is smaller than the rise word, the pulse runs across the period boundary.

Top module: `pwpm_mod`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the phase to 0, drives `pulse_out` low and loads 0 into both held words. In the first cycle after reset, `period_strobe` is high and `pulse_out` is low. Both held words are 0, which makes them equal, so no pulse appears until a new pair is loaded.
- R2: `period_strobe` is high for exactly one cycle out of every 2^PHASE_W cycles. That cycle is the one in which the phase equals 0.
- R3: When the phase equals the held rise word and differs from the held fall word, `pulse_out` is high in the next cycle.
- R4: When the phase equals the held fall word and differs from the held rise word, `pulse_out` is low in the next cycle.
- R5: `rise_pos` and `fall_pos` are captured only at a clock edge where `word_valid` is high and the phase is at its last slot (all ones). The captured pair takes effect from phase 0 of the new period. At every other slot, `word_valid` and the word inputs have no effect on the output.
- R6: If no pair is captured at a boundary, the previous pair stays in use, and the same pulse repeats in the next period.
- R7: If the fall word is less than the rise word, the output stays high from the rise slot through the boundary. It drops one cycle after the fall slot of the next period.
- R8: If the rise word equals the fall word, the output keeps its current level for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, 2^PHASE_W times the carrier rate |
| rst | input | 1 | Synchronous reset, active high |
| word_valid | input | 1 | Marks the word pair as valid; used only at the last slot |
| rise_pos | input | PHASE_W | Slot at which the pulse rises |
| fall_pos | input | PHASE_W | Slot at which the pulse falls |
| pulse_out | output | 1 | Modulated pulse train, registered |
| period_strobe | output | 1 | High during slot 0 of each carrier period |

## Verification
A phase counter that is off by even one slot shifts every edge and moves the strobe. The mismatch shows within one carrier period and then repeats in every period after it. A held word that is captured at the wrong slot, or not at all, changes the edge positions from the very next period. Swapped priority between the rise and fall events, or wrong handling of equal words, shows up in the one cycle after the selected slot. The bench compares the output on every cycle, so each of these faults is caught within a single period of the sweep.

// File: rtl/pwpm_mod.sv
module pwpm_mod #(
  parameter int PHASE_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               word_valid,
  input  logic [PHASE_W-1:0] rise_pos,
  input  logic [PHASE_W-1:0] fall_pos,
  output logic               pulse_out,
  output logic               period_strobe
);
  localparam logic [PHASE_W-1:0] LAST_SLOT = '1;

  logic [PHASE_W-1:0] phase, rise_q, fall_q;
  logic rise_hit, fall_hit, load;

  assign load          = word_valid && (phase == LAST_SLOT);
  assign rise_hit      = (phase == rise_q);
  assign fall_hit      = (phase == fall_q);
  assign period_strobe = (phase == '0);

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= '0;
      fall_q <= '0;
    end else if (load) begin
      rise_q <= rise_pos;
      fall_q <= fall_pos;
    end
  end

  // equal hits leave the level untouched
  always_ff @(posedge clk) begin
    if (rst)                        pulse_out <= 1'b0;
    else if (rise_hit != fall_hit)  pulse_out <= rise_hit;
  end

  p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
    period_strobe |=> !period_strobe);
  p_strobe_after_last_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == LAST_SLOT) |=> period_strobe);
  p_words_held_r5: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(rise_q) && $stable(fall_q)));
  p_rise_sets_r3: assert property (@(posedge clk) disable iff (rst)
    (rise_hit && !fall_hit) |=> pulse_out);
  p_fall_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (fall_hit && !rise_hit) |=> !pulse_out);
  p_equal_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (rise_q == fall_q) |=> $stable(pulse_out));
endmodule

// File: tb/tb_pwpm_mod.sv
module tb_pwpm_mod;
  localparam int W = 4;
  localparam int SLOTS = 1 << W;

  logic clk = 1'b0;
  logic rst, word_valid;
  logic [W-1:0] rise_pos, fall_pos;
  logic pulse_out, period_strobe;

  int checks = 0, failures = 0;
  int ecnt, erise, efall;
  logic epulse;
  string ptag;

  always #2 clk = ~clk;

  pwpm_mod #(.PHASE_W(W)) dut (
    .clk(clk), .rst(rst), .word_valid(word_valid),
    .rise_pos(rise_pos), .fall_pos(fall_pos),
    .pulse_out(pulse_out), .period_strobe(period_strobe)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b (cycle slot %0d)", tag, act, exp, ecnt);
    end
  endtask

  // one cycle: at negedge check outputs, drive inputs, advance the model
  task automatic step(input logic r, input logic v, input int rw, input int fw);
    logic rh, fh;
    check(ecnt == 0 ? "R2 strobe high" : "R2 strobe low", period_strobe, ecnt == 0);
    check(ptag, pulse_out, epulse);
    rst = r; word_valid = v; rise_pos = rw[W-1:0]; fall_pos = fw[W-1:0];
    if (r) begin
      ecnt = 0; erise = 0; efall = 0; epulse = 1'b0; ptag = "R1";
    end else begin
      rh = (ecnt == erise); fh = (ecnt == efall);
      if (rh && fh) ptag = "R8";
      else if (rh) ptag = "R3";
      else if (fh) ptag = "R4";
      else if (efall < erise) ptag = "R7";
      else ptag = "R6";
      if (rh != fh) epulse = rh;
      if (v && ecnt == SLOTS-1) begin erise = rw; efall = fw; end
      ecnt = (ecnt + 1) % SLOTS;
    end
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; word_valid = 1'b0; rise_pos = '0; fall_pos = '0;
    ecnt = 0; erise = 0; efall = 0; epulse = 1'b0; ptag = "R1";
    @(negedge clk);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 0, 0);
    // R1: first cycle after reset
    check("R1 strobe after reset", period_strobe, 1'b1);
    check("R1 pulse low after reset", pulse_out, 1'b0);
    // R1: zero words give no pulse for a full period
    for (int s = 0; s < SLOTS; s++) step(1'b0, 1'b0, 0, 0);
    // Exhaustive pair sweep; mid-period garbage with valid high must be ignored (R5)
    for (int p = 0; p < SLOTS*SLOTS + 1; p++) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (s == SLOTS-1) step(1'b0, 1'b1, (p % (SLOTS*SLOTS)) / SLOTS, p % SLOTS);
        else step(1'b0, 1'b1, (p*7 + s*3) % SLOTS, (p*5 + s*11) % SLOTS);
      end
    end
    // Hold (R6) and wrap (R7): load every third period only
    for (int p = 0; p < 120; p++) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (s == SLOTS-1) step(1'b0, (p % 3) == 0, (p*9 + 4) % SLOTS, (p*5 + 1) % SLOTS);
        else step(1'b0, 1'b0, s, SLOTS-1-s);
      end
    end
    // R1: reset in mid-pulse
    step(1'b0, 1'b1, 2, 12);
    for (int s = 0; s < 5; s++) step(1'b0, 1'b0, 0, 0);
    step(1'b1, 1'b0, 0, 0);
    check("R1 pulse cleared by reset", pulse_out, 1'b0);
    for (int s = 0; s < 2*SLOTS; s++) step(1'b0, 1'b0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule